// File: doc/BRIEF.md
# Exception entry sequencer

This block moves a small CPU (8-bit data, 16-bit addresses) from a reset event or an interrupt request to the first instruction of the handler. It runs one bus operation per clock. It has its own simple memory port: address, write data, read data, and read and write strobes. The CPU core gives it a snapshot of the program counter, index low byte, accumulator, condition code register and stack pointer. The core also gives it an instruction-boundary flag, a software-interrupt request and a vector of pending hardware interrupt requests.

For an interrupt, the block does the following in order:
- Stacks five bytes.
- Reads the two-byte handler address from the vector table.
- Spends one idle bus cycle.
- Prefetches three bytes of the handler into the instruction queue.

It then pulses `done_o` and presents the new program counter, stack pointer and condition codes. A CPU reset aborts any sequence at once. When the reset is released, the block runs a six-cycle sequence that reads the reset vector and fills the queue without stacking anything.

Top module: `exc_entry_seq`

## Requirements
- R1: After the synchronous block reset `rst`, `bus_rd_o`, `bus_wr_o` and `done_o` are all low, and they stay low until a request arrives.
- R2: A hardware request starts a sequence only when `boundary_i` is high, at least one `irq_pend_i` bit is set and the I bit (`ccr_i` bit 3) is clear. If I is set, or if `boundary_i` is low, there is no bus activity and no `done_o`.
- R3: The sequence first performs five writes. The addresses are SP, SP-1, SP-2, SP-3 and SP-4, counted modulo 2^16. The bytes are PC[7:0], PC[15:8], X, A and the unmodified CCR, in that order. `sp_o` then reads SP-5, and no other register byte is written.
- R4: Directly after the last write, the block reads the high byte of the handler address at the vector location V, then the low byte at V+1.
- R5: After the vector reads comes exactly one cycle with neither strobe. Then come reads of T, T+1 and T+2, where T is the handler address. `pc_o` equals T, and `q0_o`/`q1_o`/`q2_o` hold the three bytes read.
- R6: `done_o` is high for exactly the one cycle after the last prefetch read. At that point `ccr_o` equals the captured CCR with bit 3 set.
- R7: Among pending hardware requests, the lowest index wins. Entry i of `IRQ_VEC` (bits 16*i+15 down to 16*i) supplies V. The choice is fixed when the sequence starts, and requests that arrive later do not change it.
- R8: `swi_req_i` at a boundary starts the same sequence even when I is set. It takes precedence over hardware requests, and it uses V = `SWI_VEC`.
- R9: While `cpu_rst_i` is high, the current sequence is abandoned. Both strobes are low from the cycle after it is first sampled high, whatever the state of `boundary_i`.
- R10: After `cpu_rst_i` falls, the block performs only these bus operations:
  - reads of 0xFFFE and 0xFFFF;
  - one idle cycle;
  - three prefetch reads at T.
  
  It then pulses `done_o` with `sp_o` equal to `sp_i` and `ccr_o` bit 3 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| cpu_rst_i | input | 1 | CPU reset event in progress |
| boundary_i | input | 1 | Core is at an instruction boundary |
| swi_req_i | input | 1 | Software-interrupt request |
| irq_pend_i | input | NUM_IRQ | Pending hardware requests, bit 0 highest priority |
| pc_i | input | 16 | Current program counter |
| x_i | input | 8 | Index register low byte |
| a_i | input | 8 | Accumulator |
| ccr_i | input | 8 | Condition code register, bit 3 is I |
| sp_i | input | 16 | Current stack pointer |
| bus_addr_o | output | 16 | Bus address |
| bus_wdata_o | output | 8 | Bus write data |
| bus_rdata_i | input | 8 | Bus read data, valid in the cycle of the read |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| done_o | output | 1 | One-cycle completion pulse |
| pc_o | output | 16 | Handler address |
| sp_o | output | 16 | Updated stack pointer |
| ccr_o | output | 8 | Updated condition codes |
| q0_o | output | 8 | First prefetched byte |
| q1_o | output | 8 | Second prefetched byte |
| q2_o | output | 8 | Third prefetched byte |

## Verification
A request is sampled at a clock edge, and the first stack write appears in the cycle that follows. In an interrupt sequence, trace positions 0–4 are the writes, 5–6 the vector reads, 7 the idle cycle, 8–10 the prefetch reads and 11 the `done_o` pulse. A reset sequence is six bus cycles followed by `done_o` at position 6. A raised `cpu_rst_i` must silence the strobes in the very next cycle. The bench drives its inputs and samples the outputs on the falling edge, recording one trace entry per cycle. It compares every position against these fixed offsets, so an extra or a missing cycle anywhere shows up as a mismatch.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int          I_BIT     = 3;
    localparam logic [15:0] RESET_VEC = 16'hFFFE;
    localparam int          NUM_PUSH  = 5;
    localparam int          QLEN      = 3;
    localparam int          STEP_W    = $clog2(NUM_PUSH);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RHOLD,
        ST_PUSH,
        ST_VHI,
        ST_VLO,
        ST_FREE,
        ST_FILL,
        ST_DONE
    } seq_st_e;

    typedef struct packed {
        logic [15:0] pc;
        logic [7:0]  x;
        logic [7:0]  a;
        logic [7:0]  ccr;
    } cpu_ctx_t;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  wdata;
    } bus_req_t;

    // Byte stored by push step idx: low PC, high PC, X, A, CCR
    function automatic logic [7:0] push_byte(input logic [STEP_W-1:0] idx,
                                             input cpu_ctx_t c);
        logic [7:0] b;
        case (idx)
            0:       b = c.pc[7:0];
            1:       b = c.pc[15:8];
            2:       b = c.x;
            3:       b = c.a;
            default: b = c.ccr;
        endcase
        return b;
    endfunction

    function automatic logic [7:0] mask_set(input logic [7:0] ccr);
        logic [7:0] r;
        r        = ccr;
        r[I_BIT] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
    parameter int                    NUM_IRQ = 4,
    parameter logic [NUM_IRQ*16-1:0] IRQ_VEC = {16'hFFF4, 16'hFFF6, 16'hFFF8, 16'hFFFA}
) (
    input  logic [NUM_IRQ-1:0] pend_i,
    output logic               any_o,
    output logic [15:0]        vec_o
);
    // Scan from lowest priority upward so the lowest index is written last
    always_comb begin
        any_o = 1'b0;
        vec_o = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                any_o = 1'b1;
                vec_o = IRQ_VEC[i*16 +: 16];
            end
        end
    end
endmodule

// File: rtl/exc_fetch_queue.sv
module exc_fetch_queue
    import exc_entry_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  seq_st_e                   st_i,
    input  logic [STEP_W-1:0]         step_i,
    input  logic [7:0]                rdata_i,
    output logic [15:0]               target_o,
    output logic [QLEN-1:0][7:0]      q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            target_o <= '0;
            q_o      <= '0;
        end else begin
            case (st_i)
                ST_VHI:  target_o[15:8] <= rdata_i;
                ST_VLO:  target_o[7:0]  <= rdata_i;
                ST_FILL: q_o[step_i[1:0]] <= rdata_i;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
    import exc_entry_pkg::*;
#(
    parameter logic [15:0] SWI_VEC = 16'hFFFC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cpu_rst_i,
    input  logic                boundary_i,
    input  logic                swi_i,
    input  logic                irq_any_i,
    input  logic [15:0]         irq_vec_i,
    input  cpu_ctx_t            ctx_i,
    input  logic [15:0]         sp_i,
    input  logic [15:0]         target_i,
    output seq_st_e             st_o,
    output logic [STEP_W-1:0]   step_o,
    output bus_req_t            bus_o,
    output logic [15:0]         sp_o,
    output logic [7:0]          ccr_o,
    output logic                done_o
);
    seq_st_e           st_q;
    logic [STEP_W-1:0] step_q;
    cpu_ctx_t          ctx_q;
    logic [15:0]       sp_q;
    logic [15:0]       vaddr_q;
    logic [7:0]        ccr_q;
    logic              take_irq;

    assign take_irq = boundary_i && (swi_i || (irq_any_i && !ctx_i.ccr[I_BIT]));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            step_q  <= '0;
            ctx_q   <= '0;
            sp_q    <= '0;
            vaddr_q <= '0;
            ccr_q   <= '0;
        end else if (cpu_rst_i) begin
            st_q   <= ST_RHOLD;
            step_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (take_irq) begin
                        st_q    <= ST_PUSH;
                        step_q  <= '0;
                        ctx_q   <= ctx_i;
                        sp_q    <= sp_i;
                        vaddr_q <= swi_i ? SWI_VEC : irq_vec_i;
                        ccr_q   <= mask_set(ctx_i.ccr);
                    end
                end
                ST_RHOLD: begin
                    st_q    <= ST_VHI;
                    sp_q    <= sp_i;
                    vaddr_q <= RESET_VEC;
                    ccr_q   <= mask_set(ctx_i.ccr);
                end
                ST_PUSH: begin
                    sp_q <= sp_q - 16'd1;
                    if (step_q == STEP_W'(NUM_PUSH - 1)) begin
                        st_q   <= ST_VHI;
                        step_q <= '0;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                ST_VHI: st_q <= ST_VLO;
                ST_VLO: st_q <= ST_FREE;
                ST_FREE: begin
                    st_q   <= ST_FILL;
                    step_q <= '0;
                end
                ST_FILL: begin
                    if (step_q == STEP_W'(QLEN - 1)) begin
                        st_q   <= ST_DONE;
                        step_q <= '0;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_o = '0;
        case (st_q)
            ST_PUSH: begin
                bus_o.wr    = 1'b1;
                bus_o.addr  = sp_q;
                bus_o.wdata = push_byte(step_q, ctx_q);
            end
            ST_VHI: begin
                bus_o.rd   = 1'b1;
                bus_o.addr = vaddr_q;
            end
            ST_VLO: begin
                bus_o.rd   = 1'b1;
                bus_o.addr = vaddr_q + 16'd1;
            end
            ST_FILL: begin
                bus_o.rd   = 1'b1;
                bus_o.addr = target_i + 16'(step_q);
            end
            default: ;
        endcase
    end

    assign st_o   = st_q;
    assign step_o = step_q;
    assign sp_o   = sp_q;
    assign ccr_o  = ccr_q;
    assign done_o = (st_q == ST_DONE);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bus_o.rd && bus_o.wr)); // R3
    AST_MASK_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && !swi_i && ctx_i.ccr[I_BIT] && !cpu_rst_i) |=> !bus_o.wr); // R2
    AST_SP_STEP: assert property (@(posedge clk) disable iff (rst)
        (bus_o.wr && !cpu_rst_i) |=> (sp_q == $past(sp_q) - 16'd1)); // R3
    AST_FREE_GAP: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_VLO && !cpu_rst_i) |=> (!bus_o.rd && !bus_o.wr)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R6
    AST_DONE_MASK: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ccr_q[I_BIT]); // R6
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
        cpu_rst_i |=> (!bus_o.rd && !bus_o.wr)); // R9
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int                    NUM_IRQ = 4,
    parameter logic [NUM_IRQ*16-1:0] IRQ_VEC = {16'hFFF4, 16'hFFF6, 16'hFFF8, 16'hFFFA},
    parameter logic [15:0]           SWI_VEC = 16'hFFFC
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_rst_i,
    input  logic               boundary_i,
    input  logic               swi_req_i,
    input  logic [NUM_IRQ-1:0] irq_pend_i,
    input  logic [15:0]        pc_i,
    input  logic [7:0]         x_i,
    input  logic [7:0]         a_i,
    input  logic [7:0]         ccr_i,
    input  logic [15:0]        sp_i,
    output logic [15:0]        bus_addr_o,
    output logic [7:0]         bus_wdata_o,
    input  logic [7:0]         bus_rdata_i,
    output logic               bus_rd_o,
    output logic               bus_wr_o,
    output logic               done_o,
    output logic [15:0]        pc_o,
    output logic [15:0]        sp_o,
    output logic [7:0]         ccr_o,
    output logic [7:0]         q0_o,
    output logic [7:0]         q1_o,
    output logic [7:0]         q2_o
);
    logic              irq_any;
    logic [15:0]       irq_vec;
    cpu_ctx_t          ctx;
    seq_st_e           st;
    logic [STEP_W-1:0] step;
    bus_req_t          bus;
    logic [15:0]       target;
    logic [QLEN-1:0][7:0] q;

    assign ctx = '{pc: pc_i, x: x_i, a: a_i, ccr: ccr_i};

    exc_prio_pick #(
        .NUM_IRQ (NUM_IRQ),
        .IRQ_VEC (IRQ_VEC)
    ) u_pick (
        .pend_i (irq_pend_i),
        .any_o  (irq_any),
        .vec_o  (irq_vec)
    );

    exc_seq_ctrl #(
        .SWI_VEC (SWI_VEC)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cpu_rst_i  (cpu_rst_i),
        .boundary_i (boundary_i),
        .swi_i      (swi_req_i),
        .irq_any_i  (irq_any),
        .irq_vec_i  (irq_vec),
        .ctx_i      (ctx),
        .sp_i       (sp_i),
        .target_i   (target),
        .st_o       (st),
        .step_o     (step),
        .bus_o      (bus),
        .sp_o       (sp_o),
        .ccr_o      (ccr_o),
        .done_o     (done_o)
    );

    exc_fetch_queue u_queue (
        .clk      (clk),
        .rst      (rst),
        .st_i     (st),
        .step_i   (step),
        .rdata_i  (bus_rdata_i),
        .target_o (target),
        .q_o      (q)
    );

    assign bus_addr_o  = bus.addr;
    assign bus_wdata_o = bus.wdata;
    assign bus_rd_o    = bus.rd;
    assign bus_wr_o    = bus.wr;
    assign pc_o        = target;
    assign q0_o        = q[0];
    assign q1_o        = q[1];
    assign q2_o        = q[2];
endmodule

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;
    localparam logic [63:0] VTAB = {16'hFFF4, 16'hFFF6, 16'hFFF8, 16'hFFFA};
    localparam logic [15:0] SWIV = 16'hFFFC;

    logic        clk = 0, rst = 1, cpu_rst_i = 0, boundary_i = 0, swi_req_i = 0;
    logic [3:0]  irq_pend_i = 0;
    logic [15:0] pc_i = 0, sp_i = 0;
    logic [7:0]  x_i = 0, a_i = 0, ccr_i = 0;
    logic [15:0] bus_addr_o, pc_o, sp_o;
    logic [7:0]  bus_wdata_o, bus_rdata_i, ccr_o, q0_o, q1_o, q2_o;
    logic        bus_rd_o, bus_wr_o, done_o;

    int errs = 0, checks = 0;

    logic        tr_rd [0:19];
    logic        tr_wr [0:19];
    logic        tr_dn [0:19];
    logic [15:0] tr_ad [0:19];
    logic [7:0]  tr_wd [0:19];
    int          tr_n;

    always #2 clk = ~clk;

    exc_entry_seq #(.NUM_IRQ(4), .IRQ_VEC(VTAB), .SWI_VEC(SWIV)) dut (
        .clk, .rst, .cpu_rst_i, .boundary_i, .swi_req_i, .irq_pend_i,
        .pc_i, .x_i, .a_i, .ccr_i, .sp_i,
        .bus_addr_o, .bus_wdata_o, .bus_rdata_i, .bus_rd_o, .bus_wr_o,
        .done_o, .pc_o, .sp_o, .ccr_o, .q0_o, .q1_o, .q2_o
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] ad);
        return ad[7:0] ^ {ad[11:8], ad[15:12]} ^ 8'hA5;
    endfunction

    assign bus_rdata_i = mem_byte(bus_addr_o);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Trace one entry per cycle until done_o or the limit
    task automatic trace(input logic [3:0] late_irq);
        tr_n = 20;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            tr_rd[c] = bus_rd_o; tr_wr[c] = bus_wr_o; tr_dn[c] = done_o;
            tr_ad[c] = bus_addr_o; tr_wd[c] = bus_wdata_o;
            if (c == 0) begin boundary_i = 0; swi_req_i = 0; end
            if (c == 1) irq_pend_i = irq_pend_i | late_irq;
            if (done_o) begin tr_n = c + 1; break; end
        end
        irq_pend_i = 0;
        @(negedge clk);
    endtask

    task automatic expect_fetch_tail(input int base, input logic [15:0] v, input string tg);
        logic [15:0] t;
        t = {mem_byte(v), mem_byte(v + 16'd1)};
        chk(tr_rd[base] && !tr_wr[base] && tr_ad[base] == v, {tg, " R4 vector high read"}, tr_ad[base], v);
        chk(tr_rd[base+1] && tr_ad[base+1] == v + 16'd1, {tg, " R4 vector low read"}, tr_ad[base+1], v + 16'd1);
        chk(!tr_rd[base+2] && !tr_wr[base+2], {tg, " R5 idle bus cycle"}, {tr_rd[base+2], tr_wr[base+2]}, 0);
        for (int k = 0; k < 3; k++)
            chk(tr_rd[base+3+k] && tr_ad[base+3+k] == t + 16'(k), {tg, " R5 prefetch address"}, tr_ad[base+3+k], t + 16'(k));
        chk(tr_dn[base+6] && !tr_rd[base+6] && !tr_wr[base+6], {tg, " R6 done position"}, tr_n, base + 7);
        chk(tr_n == base + 7, {tg, " R6 sequence length"}, tr_n, base + 7);
        chk(pc_o == t, {tg, " R5 new PC"}, pc_o, t);
        chk({q0_o, q1_o, q2_o} == {mem_byte(t), mem_byte(t + 16'd1), mem_byte(t + 16'd2)},
            {tg, " R5 queue bytes"}, {q0_o, q1_o, q2_o}, {mem_byte(t), mem_byte(t + 16'd1), mem_byte(t + 16'd2)});
        chk(done_o == 0, {tg, " R6 done single cycle"}, done_o, 0);
    endtask

    task automatic run_irq(input logic [3:0] pend, input logic [3:0] late, input bit swi,
                           input logic [15:0] pc, input logic [7:0] x, input logic [7:0] a,
                           input logic [7:0] ccr, input logic [15:0] sp, input logic [15:0] v,
                           input string tg);
        logic [7:0] bytes [0:4];
        @(negedge clk);
        pc_i = pc; x_i = x; a_i = a; ccr_i = ccr; sp_i = sp;
        irq_pend_i = pend; swi_req_i = swi; boundary_i = 1;
        trace(late);
        bytes[0] = pc[7:0]; bytes[1] = pc[15:8]; bytes[2] = x; bytes[3] = a; bytes[4] = ccr;
        for (int i = 0; i < 5; i++) begin
            chk(tr_wr[i] && !tr_rd[i] && tr_ad[i] == sp - 16'(i), {tg, " R3 push address"}, tr_ad[i], sp - 16'(i));
            chk(tr_wd[i] == bytes[i], {tg, " R3 push byte"}, tr_wd[i], bytes[i]);
        end
        expect_fetch_tail(5, v, tg);
        chk(sp_o == sp - 16'd5, {tg, " R3 stack pointer"}, sp_o, sp - 16'd5);
        chk(ccr_o == (ccr | 8'h08), {tg, " R6 mask bit set"}, ccr_o, ccr | 8'h08);
    endtask

    task automatic t_reset_state;
        chk(!bus_rd_o && !bus_wr_o && !done_o, "R1 reset outputs quiet", {bus_rd_o, bus_wr_o, done_o}, 0);
        repeat (3) @(negedge clk);
        chk(!bus_rd_o && !bus_wr_o && !done_o, "R1 quiet without request", {bus_rd_o, bus_wr_o, done_o}, 0);
    endtask

    task automatic t_no_take;
        int seen;
        seen = 0;
        @(negedge clk);
        ccr_i = 8'h08; irq_pend_i = 4'b0001; boundary_i = 1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (bus_rd_o || bus_wr_o || done_o) seen++;
        end
        chk(seen == 0, "R2 masked request ignored", seen, 0);
        ccr_i = 8'h00; boundary_i = 0;
        seen = 0;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (bus_rd_o || bus_wr_o || done_o) seen++;
        end
        chk(seen == 0, "R2 no boundary no entry", seen, 0);
        irq_pend_i = 0;
    endtask

    task automatic t_abort_and_reset;
        int seen;
        seen = 0;
        @(negedge clk);
        pc_i = 16'h1234; ccr_i = 0; sp_i = 16'h0200; irq_pend_i = 4'b0010; boundary_i = 1;
        @(negedge clk);
        boundary_i = 0;
        chk(bus_wr_o, "R9 push started before abort", bus_wr_o, 1);
        @(negedge clk);
        cpu_rst_i = 1; irq_pend_i = 0;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (bus_rd_o || bus_wr_o || done_o) seen++;
        end
        chk(seen == 0, "R9 abort silences bus", seen, 0);
        sp_i = 16'h0400; ccr_i = 8'h41;
        cpu_rst_i = 0;
        trace(4'b0000);
        chk(tr_wr[0] == 0 && tr_rd[0], "R10 no stacking on reset", tr_wr[0], 0);
        expect_fetch_tail(0, 16'hFFFE, "R10 reset");
        chk(sp_o == 16'h0400, "R10 stack pointer unchanged", sp_o, 16'h0400);
        chk(ccr_o == 8'h49, "R10 mask bit set", ccr_o, 8'h49);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset_state();
        run_irq(4'b0001, 4'b0000, 0, 16'hC35A, 8'h11, 8'h22, 8'h01, 16'h00FF, 16'hFFFA, "R2 basic");
        run_irq(4'b1000, 4'b0000, 0, 16'h8001, 8'h7E, 8'h81, 8'hF0, 16'h0002, 16'hFFF4, "R3 wrap");
        t_no_take();
        run_irq(4'b0110, 4'b0001, 0, 16'h4000, 8'h33, 8'h44, 8'h02, 16'h0300, 16'hFFF8, "R7 priority latch");
        run_irq(4'b0001, 4'b0000, 1, 16'h5555, 8'hAA, 8'h55, 8'h08, 16'h0180, SWIV, "R8 swi masked");
        t_abort_and_reset();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule